// File: doc/BRIEF.md
# Fractional-N Feedback and Reference Divider

This block produces the two comparison pulses that a phase-frequency detector needs in a fractional-N synthesizer loop. The feedback path counts events of the prescaled RF signal and emits one pulse per divided period. The reference path counts events of the reference oscillator the same way. Both inputs arrive as one-cycle strobes (`rf_en`, `ref_en`) in a single fast system clock domain, so each divider advances only on its own strobe.

The feedback ratio is a 15-bit scaling factor. Its upper 13 bits set an integer count N. Its lower 2 bits feed a modulo-4 accumulator. On each feedback terminal count the accumulator adds the fraction, and a carry stretches the next period to N+1. Over any four consecutive feedback periods, the strobes counted therefore add up to exactly the 15-bit factor. The reference counter divides by a quarter of the chosen effective reference factor, so that it matches the fractional modulus of four. The ratio of the two pulse rates is then the factor divided by the effective reference factor. For example, a factor of 16899 against 1120 with a 17.92 MHz reference locks at 270.384 MHz, which lies on a 16 kHz grid.

A test flag copies both pulses onto two monitor outputs. All settings are plain control inputs with no handshake. A new setting is sampled only on a terminal count.

Top module: `fnd_divider`

## Requirements
- R1: Over any four consecutive feedback periods, the total number of `rf_en` strobes equals `scale_factor` (bit i has weight 2^i), for every value from 2048 to 32767.
- R2: Each feedback period lasts either N or N+1 `rf_en` strobes, where N = `scale_factor[14:2]`.
- R3: Within any four consecutive feedback periods, exactly F periods last N+1 strobes, where F = `scale_factor[1:0]`; when F is 0, every period lasts exactly N strobes.
- R4: The reference period, counted in `ref_en` strobes, is set by `ref_sel` as follows: 2'b00 gives 280, 2'b01 gives 288, 2'b10 gives 256 and 2'b11 gives 384. These are the effective factors 1120, 1152, 1024 and 1536 divided by four.
- R5: A change of `scale_factor` during a feedback period leaves that period's length unchanged and applies from the following period on.
- R6: A change of `ref_sel` during a reference period leaves that period's length unchanged and applies from the following period on.
- R7: While `test_mode` is 1, `mon_fb` equals `fb_pulse` and `mon_ref` equals `ref_pulse` in every cycle.
- R8: While `test_mode` is 0, `mon_fb` and `mon_ref` stay 0, even in a cycle where a pulse is present.
- R9: During and straight after synchronous reset (`rst` = 1), all four outputs are 0. After reset, the first `rf_en` strobe produces `fb_pulse` and the first `ref_en` strobe produces `ref_pulse`.
- R10: The counters advance only on their strobes. Idle cycles between strobes do not change any period length measured in strobes.
- R11: A pulse is 1 for exactly one clock cycle: the cycle after the clock edge that takes the terminal strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rf_en | input | 1 | One-cycle strobe per prescaled RF event |
| ref_en | input | 1 | One-cycle strobe per reference oscillator event |
| scale_factor | input | 15 | Effective feedback factor: integer part in [14:2], fraction in [1:0] |
| ref_sel | input | 2 | Reference divisor code (see R4) |
| test_mode | input | 1 | Enables the monitor copies of both pulses |
| fb_pulse | output | 1 | Feedback comparison pulse |
| ref_pulse | output | 1 | Reference comparison pulse |
| mon_fb | output | 1 | Test copy of the feedback pulse |
| mon_ref | output | 1 | Test copy of the reference pulse |

## Verification
The two dividers can reach their terminal counts in the same cycle, and both monitors must then report both pulses together. The bench provokes this by setting a factor of 1120 and code 2'b00, so both paths divide by 280, and by strobing both inputs in every cycle from reset. It expects both pulses, and both monitors while the test flag is set, on the first strobe and again on strobe 281. A second collision is a setting change that lands in the middle of a period. The bench judges it by the lengths of that period and the one after it.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  // Width of the reference down-counter; holds the largest reload (383).
  localparam int REF_W = 9;

  typedef enum logic [1:0] {
    REF_Q280 = 2'b00,
    REF_Q288 = 2'b01,
    REF_Q256 = 2'b10,
    REF_Q384 = 2'b11
  } ref_code_e;

  // Reload value is the divisor minus one (the counter counts down to zero).
  function automatic logic [REF_W-1:0] ref_reload(input logic [1:0] code);
    logic [REF_W-1:0] r;
    case (ref_code_e'(code))
      REF_Q280: r = REF_W'(279);
      REF_Q288: r = REF_W'(287);
      REF_Q256: r = REF_W'(255);
      default:  r = REF_W'(383);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fnd_frac_accum.sv
module fnd_frac_accum #(
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end

  // The residue may only move on a terminal count of the feedback counter.
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q)) else $error("accumulator moved without step"); // R3

endmodule

// File: rtl/fnd_down_counter.sv
module fnd_down_counter #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] load_val,
  output logic         tc,
  output logic         pulse,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;

  assign tc    = adv && (cnt_q == '0);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tc;
      if (tc) begin
        cnt_q <= load_val;
      end else if (adv) begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q)) else $error("counter moved without strobe"); // R10

  AST_PULSE_AFTER_EVENT: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(adv)) else $error("pulse without a preceding strobe"); // R11

endmodule

// File: rtl/fnd_main_divider.sv
module fnd_main_divider #(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 2,
  localparam int SF_W  = INT_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rf_en,
  input  logic [SF_W-1:0] factor,
  output logic            fb_pulse
);

  logic [INT_W-1:0]  n_int;
  logic [FRAC_W-1:0] frac;
  logic              tc;
  logic              carry;
  logic [INT_W-1:0]  load_val;
  logic [INT_W-1:0]  count;

  assign n_int = factor[SF_W-1:FRAC_W];
  assign frac  = factor[FRAC_W-1:0];

  // Period is load+1 strobes: N-1 for N, N for N+1.
  assign load_val = n_int - INT_W'(1) + INT_W'(carry);

  fnd_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .step  (tc),
    .frac  (frac),
    .carry (carry)
  );

  fnd_down_counter #(.W(INT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .adv      (rf_en),
    .load_val (load_val),
    .tc       (tc),
    .pulse    (fb_pulse),
    .count    (count)
  );

  // The value loaded at a terminal count is the one presented on that edge.
  AST_MAIN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> count == $past(load_val)) else $error("wrong feedback reload"); // R2

endmodule

// File: rtl/fnd_ref_divider.sv
module fnd_ref_divider
  import fnd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_en,
  input  logic [1:0] sel,
  output logic       ref_pulse
);

  logic             tc;
  logic [REF_W-1:0] load_val;
  logic [REF_W-1:0] count;

  assign load_val = ref_reload(sel);

  fnd_down_counter #(.W(REF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .adv      (ref_en),
    .load_val (load_val),
    .tc       (tc),
    .pulse    (ref_pulse),
    .count    (count)
  );

  AST_REF_LOAD_SET: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |-> (count == REF_W'(279) || count == REF_W'(287) ||
                   count == REF_W'(255) || count == REF_W'(383)))
    else $error("reference reload outside divisor set"); // R4

endmodule

// File: rtl/fnd_divider.sv
module fnd_divider #(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 2,
  localparam int SF_W  = INT_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rf_en,
  input  logic            ref_en,
  input  logic [SF_W-1:0] scale_factor,
  input  logic [1:0]      ref_sel,
  input  logic            test_mode,
  output logic            fb_pulse,
  output logic            ref_pulse,
  output logic            mon_fb,
  output logic            mon_ref
);

  fnd_main_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_main (
    .clk      (clk),
    .rst      (rst),
    .rf_en    (rf_en),
    .factor   (scale_factor),
    .fb_pulse (fb_pulse)
  );

  fnd_ref_divider u_ref (
    .clk       (clk),
    .rst       (rst),
    .ref_en    (ref_en),
    .sel       (ref_sel),
    .ref_pulse (ref_pulse)
  );

  assign mon_fb  = test_mode & fb_pulse;
  assign mon_ref = test_mode & ref_pulse;

  AST_FB_NEEDS_RF: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> $past(rf_en)) else $error("feedback pulse without RF strobe"); // R10

  AST_REF_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |-> $past(ref_en)) else $error("reference pulse without strobe"); // R10

endmodule

// File: tb/fnd_divider_bench.sv
module fnd_divider_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rf_en = 1'b0;
  logic        ref_en = 1'b0;
  logic [14:0] scale_factor = 15'd2048;
  logic [1:0]  ref_sel = 2'b00;
  logic        test_mode = 1'b0;
  logic        fb_pulse, ref_pulse, mon_fb, mon_ref;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int per [16];

  always #2 clk = ~clk;

  fnd_divider u_fnd_divider (
    .clk(clk), .rst(rst), .rf_en(rf_en), .ref_en(ref_en),
    .scale_factor(scale_factor), .ref_sel(ref_sel), .test_mode(test_mode),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .mon_fb(mon_fb), .mon_ref(mon_ref)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL R1 watchdog expired: actual=%0d expected<=%0d cycles", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit f);
    rf_en = r;
    ref_en = f;
    @(posedge clk);
    @(negedge clk);
    rf_en = 1'b0;
    ref_en = 1'b0;
  endtask

  task automatic fb_period(input int gap, output int p);
    p = 0;
    forever begin
      step(1'b1, 1'b0);
      p++;
      if (fb_pulse || p > 40000) break;
      repeat (gap) step(1'b0, 1'b0);
    end
  endtask

  task automatic ref_period(output int p);
    p = 0;
    forever begin
      step(1'b0, 1'b1);
      p++;
      if (ref_pulse || p > 4000) break;
    end
  endtask

  task automatic measure_fb(input int sf, input int gap, input int nper);
    int d;
    scale_factor = 15'(sf);
    fb_period(gap, d);
    for (int i = 0; i < nper; i++) fb_period(gap, per[i]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(fb_pulse == 0 && ref_pulse == 0, "R9", "pulses in reset", fb_pulse + ref_pulse, 0);
    chk(mon_fb == 0 && mon_ref == 0, "R9", "monitors in reset", mon_fb + mon_ref, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(fb_pulse == 0 && ref_pulse == 0, "R9", "pulses after reset", fb_pulse + ref_pulse, 0);
  endtask

  // Both dividers at 280: terminal counts coincide.
  task automatic t_coincide();
    int stray = 0;
    scale_factor = 15'd1120;
    ref_sel = 2'b00;
    test_mode = 1'b1;
    step(1'b1, 1'b1);
    chk(fb_pulse && ref_pulse, "R9", "first strobes pulse both", fb_pulse + ref_pulse, 2);
    chk(mon_fb && mon_ref, "R7", "monitors on first pulses", mon_fb + mon_ref, 2);
    step(1'b1, 1'b1);
    chk(!fb_pulse && !ref_pulse, "R11", "pulse width one cycle", fb_pulse + ref_pulse, 0);
    repeat (278) begin
      step(1'b1, 1'b1);
      if (fb_pulse || ref_pulse || mon_fb || mon_ref) stray++;
    end
    chk(stray == 0, "R3", "no early pulse in 280 period", stray, 0);
    step(1'b1, 1'b1);
    chk(fb_pulse && ref_pulse, "R4", "coincident pulse at strobe 281", fb_pulse + ref_pulse, 2);
    chk(mon_fb == fb_pulse && mon_ref == ref_pulse, "R7", "monitors track", mon_fb + mon_ref, 2);
    test_mode = 1'b0;
    repeat (279) step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk(fb_pulse && ref_pulse, "R3", "coincident pulse again", fb_pulse + ref_pulse, 2);
    chk(mon_fb == 0 && mon_ref == 0, "R8", "monitors quiet without test", mon_fb + mon_ref, 0);
  endtask

  task automatic t_fb_frac();
    int s0 = 0, s1 = 0, longs = 0, odd = 0;
    measure_fb(16899, 0, 8);
    for (int i = 0; i < 8; i++) begin
      if (per[i] != 4224 && per[i] != 4225) odd++;
      if (i < 4) s0 += per[i]; else s1 += per[i];
      if (i < 4 && per[i] == 4225) longs++;
    end
    chk(odd == 0, "R2", "periods are N or N+1 (16899)", odd, 0);
    chk(s0 == 16899, "R1", "sum of four periods (16899) first", s0, 16899);
    chk(s1 == 16899, "R1", "sum of four periods (16899) second", s1, 16899);
    chk(longs == 3, "R3", "N+1 periods in four (F=3)", longs, 3);
  endtask

  task automatic t_fb_int();
    int bad = 0, s = 0;
    measure_fb(2048, 0, 4);
    for (int i = 0; i < 4; i++) begin
      s += per[i];
      if (per[i] != 512) bad++;
    end
    chk(bad == 0, "R3", "F=0 periods all 512", bad, 0);
    chk(s == 2048, "R1", "sum of four periods (2048)", s, 2048);
  endtask

  task automatic t_fb_max();
    int s = 0;
    measure_fb(32767, 0, 4);
    for (int i = 0; i < 4; i++) s += per[i];
    chk(s == 32767, "R1", "sum of four periods (32767)", s, 32767);
  endtask

  task automatic t_fb_sparse();
    int s = 0;
    measure_fb(2049, 2, 4);
    for (int i = 0; i < 4; i++) s += per[i];
    chk(s == 2049, "R10", "sparse strobes sum (2049)", s, 2049);
  endtask

  task automatic t_fb_midchange();
    int p, stray = 0;
    measure_fb(2048, 0, 0);
    repeat (100) begin
      step(1'b1, 1'b0);
      if (fb_pulse) stray++;
    end
    scale_factor = 15'd4096;
    fb_period(0, p);
    chk(stray == 0 && p + 100 == 512, "R5", "period in progress keeps old N", p + 100, 512);
    fb_period(0, p);
    chk(p == 1024, "R5", "new N after terminal", p, 1024);
  endtask

  task automatic t_ref_codes();
    int exp_div [4] = '{280, 288, 256, 384};
    for (int s = 0; s < 4; s++) begin
      int d, p0, p1;
      ref_sel = 2'(s);
      ref_period(d);
      ref_period(p0);
      ref_period(p1);
      chk(p0 == exp_div[s] && p1 == exp_div[s], "R4", "reference divisor per code",
          p0, exp_div[s]);
    end
  endtask

  task automatic t_ref_midchange();
    int d, p;
    ref_sel = 2'b10;
    ref_period(d);
    repeat (50) step(1'b0, 1'b1);
    ref_sel = 2'b11;
    ref_period(p);
    chk(p + 50 == 256, "R6", "reference period in progress keeps old code", p + 50, 256);
    ref_period(p);
    chk(p == 384, "R6", "new reference code after terminal", p, 384);
  endtask

  initial begin
    t_reset();
    t_coincide();
    t_fb_frac();
    t_fb_int();
    t_fb_max();
    t_fb_sparse();
    t_fb_midchange();
    t_ref_codes();
    t_ref_midchange();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule